// File: doc/BRIEF.md
# Posted Write Acknowledge Tracker

This block sits beside an outbound request channel and watches two things. The first is header beats that open a posted write. The second is single-cycle acknowledge pulses that come back from the far side. Each posted write creates a debt of exactly one acknowledge. The block records the cycle in which each write appeared. Acknowledges pay off the oldest debt first, and the block compares the age of that debt against a lower and an upper latency bound. It also enforces a ceiling on how many writes may be waiting at once.

The block only observes; it drives nothing back toward either party. The header and acknowledge inputs are therefore plain qualifiers with no ready signal, and no back-pressure is ever applied. A header or acknowledge is taken in every cycle in which its valid bit is high. The outputs are the number of writes currently waiting and four sticky error flags: early acknowledge, late acknowledge, in-flight overflow and orphan acknowledge. A clear input drops the flags.

Top module: `wr_ack_tracker`

## Requirements
- R1: A write obligation is opened only when `hdr_vld` is high, `hdr_bypass` is low and `hdr_cmd` equals 6'b010010 or 6'b010110. Any other header leaves `outstanding` unchanged.
- R2: `outstanding` is updated at the clock edge that samples the event. It equals the number of accepted writes minus the number retired by acknowledges or by timeout.
- R3: An acknowledge whose oldest pending write was sampled at least MIN_LAT edges earlier raises no flag. An age below MIN_LAT sets `err_early` at the next edge, and the write is still retired.
- R4: A pending write is retired with `err_late` set once its age reaches MAX_LAT+1 edges with no acknowledge. An acknowledge at an age of exactly MAX_LAT is accepted without any flag.
- R5: A write header that arrives while DEPTH writes are pending, and while nothing is retired in the same cycle, is discarded and sets `err_overflow`. If a retirement happens in the same cycle, the header is accepted.
- R6: An acknowledge that arrives while nothing is pending sets `err_orphan`. A write header in the same cycle does not cover it, and that header is still accepted.
- R7: Each flag stays set until `err_clr` is sampled high. An error that occurs in the same cycle as the clear leaves its flag set.
- R8: Acknowledges retire pending writes strictly oldest first.
- R9: Asserting `rst_n` low empties the pending set at once and clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_vld | input | 1 | Outbound header beat is present |
| hdr_cmd | input | 6 | Command field of the header |
| hdr_bypass | input | 1 | Bypass qualifier of the header |
| ack_vld | input | 1 | Write acknowledge pulse |
| err_clr | input | 1 | Clears all sticky flags |
| outstanding | output | $clog2(DEPTH+1) | Writes awaiting acknowledge |
| err_early | output | 1 | Acknowledge came below the minimum latency |
| err_late | output | 1 | A write exceeded the maximum latency |
| err_overflow | output | 1 | Write seen with the pending set full |
| err_orphan | output | 1 | Acknowledge seen with nothing pending |

## Verification
The bench builds the tracker with DEPTH=4, MIN_LAT=2 and MAX_LAT=20, which keeps the minimum-latency bound at its intended value. A fifth write fills and overruns the pending set within a few cycles. The timeout boundary, both the accepted acknowledge at age 20 and the forced retirement at age 21, is reached in a short directed run instead of tens of thousands of cycles. Mixed ages in the pending set show that retirement is oldest first, because retiring the youngest entry would trip the early flag.

// File: rtl/wat_pkg.sv
package wat_pkg;
  localparam int CMD_W = 6;
  localparam logic [CMD_W-1:0] CMD_WR_INVAL = 6'b010010;
  localparam logic [CMD_W-1:0] CMD_WR_MERGE = 6'b010110;

  localparam int N_ERR      = 4;
  localparam int ERR_EARLY  = 0;
  localparam int ERR_LATE   = 1;
  localparam int ERR_OVF    = 2;
  localparam int ERR_ORPHAN = 3;

  function automatic logic opens_debt(input logic [CMD_W-1:0] cmd, input logic byp);
    return !byp && ((cmd == CMD_WR_INVAL) || (cmd == CMD_WR_MERGE));
  endfunction
endpackage

// File: rtl/wat_cmd_decode.sv
module wat_cmd_decode
  import wat_pkg::*;
(
  input  logic             hdr_vld,
  input  logic [CMD_W-1:0] hdr_cmd,
  input  logic             hdr_bypass,
  output logic             wr_seen
);
  assign wr_seen = hdr_vld && opens_debt(hdr_cmd, hdr_bypass);
endmodule

// File: rtl/wat_stamp_queue.sv
module wat_stamp_queue #(
  parameter int DEPTH = 16,
  parameter int TS_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [TS_W-1:0]  push_ts,
  output logic [TS_W-1:0]  head_ts,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TS_W-1:0]  slot [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign head_ts = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= push_ts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/wat_err_flags.sv
module wat_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr)    flags[g] <= 1'b0;
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr) |=> flags[g]);

    // R7
    flag_setwins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> flags[g]);
  end
endmodule

// File: rtl/wr_ack_tracker.sv
module wr_ack_tracker
  import wat_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 48000,
  localparam int TS_W   = $clog2(MAX_LAT + 2),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_vld,
  input  logic [5:0]       hdr_cmd,
  input  logic             hdr_bypass,
  input  logic             ack_vld,
  input  logic             err_clr,
  output logic [CNT_W-1:0] outstanding,
  output logic             err_early,
  output logic             err_late,
  output logic             err_overflow,
  output logic             err_orphan
);
  localparam logic [TS_W-1:0] MIN_A = TS_W'(MIN_LAT);
  localparam logic [TS_W-1:0] MAX_A = TS_W'(MAX_LAT);
  localparam logic [TS_W-1:0] TMO_A = TS_W'(MAX_LAT + 1);

  logic              wr_seen;
  logic [TS_W-1:0]   now, head_ts, age;
  logic              q_empty, q_full;
  logic              ack_hit, overdue, pop, push;
  logic [N_ERR-1:0]  err_set, err_q;

  wat_cmd_decode u_dec (
    .hdr_vld    (hdr_vld),
    .hdr_cmd    (hdr_cmd),
    .hdr_bypass (hdr_bypass),
    .wr_seen    (wr_seen)
  );

  // Free-running cycle stamp; entries leave before their age can wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  assign age     = now - head_ts;
  assign ack_hit = ack_vld && !q_empty;
  assign overdue = !q_empty && (age > MAX_A);
  assign pop     = ack_hit || overdue;
  assign push    = wr_seen && (!q_full || pop);

  always_comb begin
    err_set             = '0;
    err_set[ERR_EARLY]  = ack_hit && (age < MIN_A);
    err_set[ERR_LATE]   = overdue;
    err_set[ERR_OVF]    = wr_seen && q_full && !pop;
    err_set[ERR_ORPHAN] = ack_vld && q_empty;
  end

  wat_stamp_queue #(.DEPTH(DEPTH), .TS_W(TS_W)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .pop     (pop),
    .push_ts (now),
    .head_ts (head_ts),
    .count   (outstanding),
    .empty   (q_empty),
    .full    (q_full)
  );

  wat_err_flags #(.N(N_ERR)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (err_clr),
    .set   (err_set),
    .flags (err_q)
  );

  assign err_early    = err_q[ERR_EARLY];
  assign err_late     = err_q[ERR_LATE];
  assign err_overflow = err_q[ERR_OVF];
  assign err_orphan   = err_q[ERR_ORPHAN];

  // R4
  age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_empty |-> (age <= TMO_A));

  // R6
  orphan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && outstanding == '0) |=> err_orphan);

  // R3
  early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && outstanding != '0 && age < MIN_A) |=> err_early);

  // R1
  ignore_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_seen && !ack_vld && !overdue) |=> $stable(outstanding));
endmodule

// File: tb/wr_ack_tracker_bench.sv
module wr_ack_tracker_bench;
  localparam int DEPTH = 4;
  localparam int MINL  = 2;
  localparam int MAXL  = 20;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [5:0] WI = 6'b010010;
  localparam logic [5:0] WM = 6'b010110;
  localparam logic [5:0] RD = 6'b001010;
  localparam int NV = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_vld = 1'b0, hdr_bypass = 1'b0, ack_vld = 1'b0, err_clr = 1'b0;
  logic [5:0] hdr_cmd = '0;
  logic [CW-1:0] outstanding;
  logic err_early, err_late, err_overflow, err_orphan;

  int applied = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  wr_ack_tracker #(.DEPTH(DEPTH), .MIN_LAT(MINL), .MAX_LAT(MAXL)) u_wr_ack_tracker (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_cmd(hdr_cmd),
    .hdr_bypass(hdr_bypass), .ack_vld(ack_vld), .err_clr(err_clr),
    .outstanding(outstanding), .err_early(err_early), .err_late(err_late),
    .err_overflow(err_overflow), .err_orphan(err_orphan)
  );

  // vector: {hdr, cmd[5:0], bypass, ack, clr, exp_cnt[3:0], exp_flags{orphan,ovf,late,early}}
  function automatic logic [17:0] mk(input logic h, input logic [5:0] c, input logic b,
                                     input logic a, input logic x, input logic [3:0] n,
                                     input logic [3:0] f);
    return {h, c, b, a, x, n, f};
  endfunction

  localparam logic [17:0] VEC [NV] = '{
    mk(0, 0,  0, 0, 0, 0, 4'b0000),  // 0 idle
    mk(1, WI, 0, 0, 0, 1, 4'b0000),  // 1 write-inval
    mk(0, 0,  0, 0, 0, 1, 4'b0000),  // 2
    mk(0, 0,  0, 1, 0, 0, 4'b0000),  // 3 ack age 2
    mk(1, WM, 0, 0, 0, 1, 4'b0000),  // 4 write-merge
    mk(0, 0,  0, 1, 0, 0, 4'b0001),  // 5 ack age 1 early
    mk(0, 0,  0, 0, 1, 0, 4'b0000),  // 6 clear
    mk(1, RD, 0, 0, 0, 0, 4'b0000),  // 7 read ignored
    mk(1, WI, 1, 0, 0, 0, 4'b0000),  // 8 bypass ignored
    mk(0, 0,  0, 1, 0, 0, 4'b1000),  // 9 orphan
    mk(0, 0,  0, 0, 1, 0, 4'b0000),  // 10 clear
    mk(1, WI, 0, 0, 0, 1, 4'b0000),  // 11
    mk(1, WM, 0, 0, 0, 2, 4'b0000),  // 12
    mk(1, WI, 0, 0, 0, 3, 4'b0000),  // 13
    mk(1, WI, 0, 0, 0, 4, 4'b0000),  // 14 full
    mk(1, WI, 0, 0, 0, 4, 4'b0100),  // 15 overflow
    mk(1, WI, 0, 1, 0, 4, 4'b0100),  // 16 push with pop
    mk(0, 0,  0, 1, 1, 3, 4'b0000),  // 17 clear + ack
    mk(0, 0,  0, 1, 0, 2, 4'b0000),  // 18
    mk(0, 0,  0, 1, 0, 1, 4'b0000),  // 19
    mk(0, 0,  0, 1, 0, 0, 4'b0000),  // 20
    mk(1, WI, 0, 1, 0, 1, 4'b1000),  // 21 ack on empty + write
    mk(0, 0,  0, 0, 1, 1, 4'b0000),  // 22 clear
    mk(0, 0,  0, 1, 0, 0, 4'b0000),  // 23 ack age 2
    mk(1, WM, 0, 0, 0, 1, 4'b0000),  // 24
    mk(0, 0,  0, 0, 0, 1, 4'b0000),  // 25
    mk(0, 0,  0, 0, 0, 1, 4'b0000),  // 26
    mk(1, WI, 0, 0, 0, 2, 4'b0000),  // 27
    mk(0, 0,  0, 1, 0, 1, 4'b0000),  // 28 oldest (age 4) retired
    mk(0, 0,  0, 1, 0, 0, 4'b0000)   // 29 next (age 2) retired
  };

  function automatic string tag_of(input int i);
    case (i)
      1, 4, 7, 8:          return "R1";
      3, 5, 23:            return "R3";
      15, 16:              return "R5";
      9, 21:               return "R6";
      6, 10, 17, 22:       return "R7";
      18, 19, 20, 28, 29:  return "R8";
      default:             return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] n, input logic [3:0] f);
    logic [3:0] got_f;
    got_f = {err_orphan, err_overflow, err_late, err_early};
    applied++;
    if (4'(outstanding) !== n || got_f !== f) begin
      miscompares++;
      $display("FAIL %s: actual cnt=%0d flags=%b expected cnt=%0d flags=%b",
               req, outstanding, got_f, n, f);
    end
  endtask

  task automatic step(input logic h, input logic [5:0] c, input logic b,
                      input logic a, input logic x);
    hdr_vld = h; hdr_cmd = c; hdr_bypass = b; ack_vld = a; err_clr = x;
    @(posedge clk);
    @(negedge clk);
    hdr_vld = 0; hdr_cmd = '0; hdr_bypass = 0; ack_vld = 0; err_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", 0, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16:11], VEC[i][10], VEC[i][9], VEC[i][8]);
      chk(tag_of(i), VEC[i][7:4], VEC[i][3:0]);
    end

    // R4: no ack, head survives age MAXL, retired at MAXL+1
    step(1, WI, 0, 0, 0);
    repeat (MAXL) step(0, 0, 0, 0, 0);
    chk("R4", 1, 4'b0000);
    step(0, 0, 0, 0, 0);
    chk("R4", 0, 4'b0010);

    // R4: ack at exactly MAXL is accepted
    step(0, 0, 0, 0, 1);
    step(1, WM, 0, 0, 0);
    repeat (MAXL - 1) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    chk("R4", 0, 4'b0000);

    // R7: orphan in same cycle as clear stays set
    step(0, 0, 0, 1, 1);
    chk("R7", 0, 4'b1000);

    // R9: reset mid-activity
    step(1, WI, 0, 0, 0);
    step(1, WM, 0, 0, 0);
    chk("R2", 2, 4'b1000);
    rst_n = 1'b0;
    #1;
    chk("R9", 0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    chk("R9", 0, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R2: watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule